// File: doc/BRIEF.md
# Online Core Test Sequencer

This block schedules periodic self-test of a large array of identical processing cores. When a test-cycle trigger arrives it fetches short test snippets from a snippet memory, broadcasts each snippet word as a command, and then tells each test group in turn to apply the stored snippet. It waits for each group to signal completion before it moves to the next group. After the last round it sends one status query addressed to every tester. A combined feedback bit, the AND of all responding testers, tells it whether the whole array is healthy.

When the combined result shows a fault, the sequencer narrows the search in three steps. It queries the groups one by one, then the clusters of the failing group, then the cores of the failing cluster. It then sends a retest to the suspected core and queries that core once more. A second failure makes it send a disable command for the core and record the core's ID in a sticky log. A clean result is taken as a transient fault and the sequencer goes back to idle. The number of groups, clusters per group, cores per cluster and snippets per cycle are inputs, so the schedule can change without any hardware change. A programmable wait, set to the worst-case latency of the broadcast and feedback paths, comes before every feedback sample.

Top module: `test_sequencer`

## Requirements
- R1: After reset, `busy`, `cmd_valid` and `fault_log_valid` are low.
- R2: A trigger while idle starts a test cycle. `busy` is high from the cycle after the trigger until the sequencer returns to idle. A trigger while busy has no effect on the command stream. Every command except a disable command is issued while `busy` is high.
- R3: Each round sends snippet number s as SNIPPET_WORDS commands with opcode 5. Word w is read from memory address s*SNIPPET_WORDS+w. The group and cluster fields are 4'hF, the core field holds w, and the data field holds the word read. Snippets go out in order 0 to cfg_snippets-1.
- R4: After each snippet, an apply command (opcode 1) with group field g and wildcard cluster and core fields is sent for g = 0 to cfg_groups-1 in order. The next command is not issued until feedback has been seen high after that apply.
- R5: After the last round a status query (opcode 3) with all three fields 4'hF is sent. If feedback is high at the sample, the sequencer returns to idle.
- R6: After any command other than a snippet word, the next command comes at least cfg_wait+2 cycles later. Feedback is therefore never sampled within the programmed latency window.
- R7: A failing full query starts diagnosis. Status queries (g,F,F) go out for ascending g until feedback reads low. Then (g,c,F) goes out for ascending c, then (g,c,k) for ascending k, each scan stopping at the first failing index. A field value of 4'hF is a wildcard.
- R8: If a scan level reaches its count (cfg_groups, cfg_clusters or cfg_cores) with no failing index, the sequencer returns to idle with no retest and no disable.
- R9: For a suspected core (g,c,k), a retest command (opcode 2) is sent. Once feedback has been seen high, a status query (g,c,k) follows. A low result sends a disable command (opcode 4) for (g,c,k) and loads the fault log. A high result returns to idle with no disable.
- R10: `fault_log` holds {group,cluster,core} of the last disabled core and changes only when a disable command is issued. `fault_log_valid` stays high once set.
- R11: A command word is {opcode[30:28], group[27:24], cluster[23:20], core[19:16], data[15:0]}. The data field is zero in every command except a snippet word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigger | input | 1 | Starts a test cycle when idle |
| cfg_groups | input | 4 | Number of test groups (1 to 15) |
| cfg_clusters | input | 4 | Clusters per group (1 to 15) |
| cfg_cores | input | 4 | Cores per cluster (1 to 15) |
| cfg_snippets | input | 4 | Snippets per test cycle (1 to 15) |
| cfg_wait | input | 8 | Broadcast plus feedback latency in cycles |
| fb_ok | input | 1 | Combined feedback: 1 done or healthy, 0 busy or faulty |
| mem_en | output | 1 | Snippet memory read enable |
| mem_addr | output | 6 | Snippet memory read address |
| mem_rdata | input | 16 | Snippet memory data, one cycle after the address |
| cmd_valid | output | 1 | Command word valid for this cycle |
| cmd_word | output | 31 | Command toward the broadcast network |
| busy | output | 1 | Test cycle or diagnosis in progress |
| fault_log_valid | output | 1 | A core has been disabled since reset |
| fault_log | output | 12 | {group,cluster,core} of the last disabled core |

## Verification
Assertions check on every cycle the properties that hold at the command port alone. These are the quiet state after reset, that commands appear only while busy, the minimum spacing after a non-snippet command, the wildcard fields and zero data rules of the word format, and the tie between a disable command and the fault log. Only the bench's scenarios can show the ordering of the whole schedule and the result of each diagnosis. They cover a healthy array, a permanent fault, a transient fault cleared by the retest, a fault that vanishes before the group scan, and a disabled core that no longer reports. Those scenarios also show that the snippet data matches the memory and that a trigger while busy leaves the stream unchanged.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_APPLY   = 3'd1,
    OP_RETEST  = 3'd2,
    OP_REPORT  = 3'd3,
    OP_DISABLE = 3'd4,
    OP_SNIPPET = 3'd5
  } ts_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_EVAL
  } ts_state_e;

  // what the pending command was, decides the step after the wait
  typedef enum logic [2:0] {
    K_APPLY,
    K_FULL,
    K_DIAG,
    K_RETEST,
    K_RECHECK,
    K_DISABLE
  } ts_kind_e;

endpackage

// File: rtl/ts_wait_timer.sv
module ts_wait_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ts_cmd_reg.sv
module ts_cmd_reg #(
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 16,
  localparam int CMD_W  = 3 + 3*FIELD_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue,
  input  ts_pkg::ts_op_e     op,
  input  logic [FIELD_W-1:0] grp,
  input  logic [FIELD_W-1:0] clu,
  input  logic [FIELD_W-1:0] core,
  input  logic [DATA_W-1:0]  data,
  output logic               cmd_valid,
  output logic [CMD_W-1:0]   cmd_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      cmd_valid <= issue;
      if (issue) begin
        cmd_word <= {op, grp, clu, core, data};
      end
    end
  end
endmodule

// File: rtl/test_sequencer.sv
module test_sequencer #(
  parameter int FIELD_W    = 4,
  parameter int DATA_W     = 16,
  parameter int SNIP_CNT_W = 4,
  parameter int WORDS_LOG2 = 2,
  parameter int WAIT_W     = 8,
  localparam int CMD_W     = 3 + 3*FIELD_W + DATA_W,
  localparam int ADDR_W    = SNIP_CNT_W + WORDS_LOG2,
  localparam int LOG_W     = 3*FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trigger,
  input  logic [FIELD_W-1:0]    cfg_groups,
  input  logic [FIELD_W-1:0]    cfg_clusters,
  input  logic [FIELD_W-1:0]    cfg_cores,
  input  logic [SNIP_CNT_W-1:0] cfg_snippets,
  input  logic [WAIT_W-1:0]     cfg_wait,
  input  logic                  fb_ok,
  output logic                  mem_en,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  cmd_valid,
  output logic [CMD_W-1:0]      cmd_word,
  output logic                  busy,
  output logic                  fault_log_valid,
  output logic [LOG_W-1:0]      fault_log
);
  import ts_pkg::*;

  localparam logic [FIELD_W-1:0]    WILD      = '1;
  localparam logic [WORDS_LOG2-1:0] LAST_WORD = '1;

  ts_state_e state;
  ts_kind_e  kind;
  logic [1:0]            level;
  logic [FIELD_W-1:0]    idx, grp_i, sel_g, sel_c, sel_k;
  logic [SNIP_CNT_W-1:0] snip_i;
  logic [WORDS_LOG2-1:0] word_i;
  logic [FIELD_W-1:0]    scan_limit;
  logic                  timer_expired;

  logic               iss;
  ts_op_e             iss_op;
  logic [FIELD_W-1:0] iss_g, iss_c, iss_k;
  logic [DATA_W-1:0]  iss_d;

  ts_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (state == ST_ISSUE),
    .load_val (cfg_wait),
    .expired  (timer_expired)
  );

  ts_cmd_reg #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .issue     (iss),
    .op        (iss_op),
    .grp       (iss_g),
    .clu       (iss_c),
    .core      (iss_k),
    .data      (iss_d),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word)
  );

  assign mem_en = (state == ST_FETCH);

  always_comb begin
    case (level)
      2'd0:    scan_limit = cfg_groups;
      2'd1:    scan_limit = cfg_clusters;
      default: scan_limit = cfg_cores;
    endcase
  end

  // command fields for the word registered at the end of this cycle
  always_comb begin
    iss    = 1'b0;
    iss_op = OP_NONE;
    iss_g  = WILD;
    iss_c  = WILD;
    iss_k  = WILD;
    iss_d  = '0;
    if (state == ST_LATCH) begin
      iss    = 1'b1;
      iss_op = OP_SNIPPET;
      iss_k  = FIELD_W'(word_i);
      iss_d  = mem_rdata;
    end else if (state == ST_ISSUE) begin
      iss = 1'b1;
      case (kind)
        K_APPLY: begin
          iss_op = OP_APPLY;
          iss_g  = grp_i;
        end
        K_FULL: iss_op = OP_REPORT;
        K_DIAG: begin
          iss_op = OP_REPORT;
          case (level)
            2'd0: iss_g = idx;
            2'd1: begin
              iss_g = sel_g;
              iss_c = idx;
            end
            default: begin
              iss_g = sel_g;
              iss_c = sel_c;
              iss_k = idx;
            end
          endcase
        end
        K_RETEST, K_RECHECK, K_DISABLE: begin
          iss_op = (kind == K_RETEST)  ? OP_RETEST :
                   (kind == K_RECHECK) ? OP_REPORT : OP_DISABLE;
          iss_g  = sel_g;
          iss_c  = sel_c;
          iss_k  = sel_k;
        end
        default: iss_op = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      kind            <= K_APPLY;
      level           <= '0;
      idx             <= '0;
      grp_i           <= '0;
      sel_g           <= '0;
      sel_c           <= '0;
      sel_k           <= '0;
      snip_i          <= '0;
      word_i          <= '0;
      mem_addr        <= '0;
      busy            <= 1'b0;
      fault_log_valid <= 1'b0;
      fault_log       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trigger) begin
            busy     <= 1'b1;
            snip_i   <= '0;
            word_i   <= '0;
            mem_addr <= '0;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LATCH;
        ST_LATCH: begin
          if (word_i == LAST_WORD) begin
            word_i <= '0;
            grp_i  <= '0;
            kind   <= K_APPLY;
            state  <= ST_ISSUE;
          end else begin
            word_i   <= word_i + 1'b1;
            mem_addr <= mem_addr + 1'b1;
            state    <= ST_FETCH;
          end
        end
        ST_ISSUE: begin
          if (kind == K_DISABLE) begin
            fault_log       <= {sel_g, sel_c, sel_k};
            fault_log_valid <= 1'b1;
            busy            <= 1'b0;
            state           <= ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (timer_expired) begin
            state <= (kind == K_APPLY || kind == K_RETEST) ? ST_DONE : ST_EVAL;
          end
        end
        ST_DONE: begin
          if (fb_ok) begin
            if (kind == K_RETEST) begin
              kind  <= K_RECHECK;
              state <= ST_ISSUE;
            end else if ({1'b0, grp_i} + 1'b1 < {1'b0, cfg_groups}) begin
              grp_i <= grp_i + 1'b1;
              state <= ST_ISSUE;
            end else if ({1'b0, snip_i} + 1'b1 < {1'b0, cfg_snippets}) begin
              snip_i   <= snip_i + 1'b1;
              mem_addr <= {snip_i + 1'b1, {WORDS_LOG2{1'b0}}};
              state    <= ST_FETCH;
            end else begin
              kind  <= K_FULL;
              state <= ST_ISSUE;
            end
          end
        end
        ST_EVAL: begin
          case (kind)
            K_FULL: begin
              if (fb_ok) begin
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else begin
                kind  <= K_DIAG;
                level <= 2'd0;
                idx   <= '0;
                state <= ST_ISSUE;
              end
            end
            K_DIAG: begin
              if (!fb_ok) begin
                case (level)
                  2'd0:    sel_g <= idx;
                  2'd1:    sel_c <= idx;
                  default: sel_k <= idx;
                endcase
                if (level == 2'd2) begin
                  kind <= K_RETEST;
                end else begin
                  level <= level + 1'b1;
                  idx   <= '0;
                end
                state <= ST_ISSUE;
              end else if ({1'b0, idx} + 1'b1 >= {1'b0, scan_limit}) begin
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else begin
                idx   <= idx + 1'b1;
                state <= ST_ISSUE;
              end
            end
            default: begin
              if (!fb_ok) begin
                kind  <= K_DISABLE;
                state <= ST_ISSUE;
              end else begin
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 16,
  parameter int WAIT_W  = 8,
  localparam int CMD_W  = 3 + 3*FIELD_W + DATA_W,
  localparam int LOG_W  = 3*FIELD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_word,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              fault_log_valid,
  input logic [LOG_W-1:0]  fault_log
);
  logic [2:0]         op;
  logic [FIELD_W-1:0] f_g, f_c, f_k;
  logic [DATA_W-1:0]  f_d;
  logic [WAIT_W:0]    gap;
  logic               prev_slow;

  assign op  = cmd_word[CMD_W-1 -: 3];
  assign f_g = cmd_word[CMD_W-4 -: FIELD_W];
  assign f_c = cmd_word[CMD_W-4-FIELD_W -: FIELD_W];
  assign f_k = cmd_word[CMD_W-4-2*FIELD_W -: FIELD_W];
  assign f_d = cmd_word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= '0;
      prev_slow <= 1'b0;
    end else if (cmd_valid) begin
      gap       <= '0;
      prev_slow <= (op != 3'd5);
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !cmd_valid && !fault_log_valid));

  assert_cmd_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op != 3'd4) |-> busy);

  assert_snip_fields_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == 3'd5) |-> (f_g == '1 && f_c == '1));

  assert_latency_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && prev_slow) |-> (gap > {1'b0, cfg_wait}));

  assert_disable_logged_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == 3'd4) |-> (fault_log_valid && fault_log == {f_g, f_c, f_k}));

  assert_log_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(fault_log) || $rose(fault_log_valid)) |-> (cmd_valid && op == 3'd4));

  assert_word_format_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op != 3'd5) |-> (f_d == '0 && op >= 3'd1 && op <= 3'd4));
endmodule

bind test_sequencer ts_checker #(
  .FIELD_W (FIELD_W),
  .DATA_W  (DATA_W),
  .WAIT_W  (WAIT_W)
) u_ts_checker (
  .clk             (clk),
  .rst             (rst),
  .busy            (busy),
  .cmd_valid       (cmd_valid),
  .cmd_word        (cmd_word),
  .cfg_wait        (cfg_wait),
  .fault_log_valid (fault_log_valid),
  .fault_log       (fault_log)
);

// File: tb/test_sequencer_test.sv
`timescale 1ns/1ps
module test_sequencer_test;
  localparam logic [3:0] F = 4'hF;
  localparam int WAITV = 3;
  localparam int APPLY_DELAY = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigger = 1'b0;
  logic [3:0] cfg_groups = 4'd3, cfg_clusters = 4'd2, cfg_cores = 4'd3, cfg_snippets = 4'd2;
  logic [7:0] cfg_wait = 8'(WAITV);
  logic fb_ok = 1'b1;
  logic mem_en;
  logic [5:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic cmd_valid;
  logic [30:0] cmd_word;
  logic busy, fault_log_valid;
  logic [11:0] fault_log;

  int checks = 0, fails = 0, cyc = 0;
  logic [30:0] exp_q[$];

  // fault model: mode 0 permanent, 1 cleared by retest, 2 seen only by the full query
  int f_mode = -1;
  logic [3:0] fg, fc, fk;
  logic f_disabled = 1'b0;
  int apply_cnt = 0;
  logic apply_pend = 1'b0;
  int last_cmd_cyc = -100;
  logic last_slow = 1'b0;

  test_sequencer uut (
    .clk(clk), .rst(rst), .trigger(trigger),
    .cfg_groups(cfg_groups), .cfg_clusters(cfg_clusters), .cfg_cores(cfg_cores),
    .cfg_snippets(cfg_snippets), .cfg_wait(cfg_wait), .fb_ok(fb_ok),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .busy(busy),
    .fault_log_valid(fault_log_valid), .fault_log(fault_log)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_word(int a);
    return 16'((a * 4951) ^ 16'hA5A5);
  endfunction

  always_ff @(posedge clk) if (mem_en) mem_rdata <= mem_word(int'(mem_addr));

  function automatic logic [30:0] mk(int op, logic [3:0] g, logic [3:0] c, logic [3:0] k, logic [15:0] d);
    return {3'(op), g, c, k, d};
  endfunction

  function automatic string tag_of(logic [30:0] w);
    case (w[30:28])
      3'd5: return "R3";
      3'd1: return "R4";
      3'd2, 3'd4: return "R9";
      3'd3: return (w[27:24] == F) ? "R5" : "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic hit(logic [3:0] g, logic [3:0] c, logic [3:0] k);
    if (f_mode < 0 || f_disabled) return 1'b0;
    if (f_mode == 2) return (g == F && c == F && k == F);
    return (g == F || g == fg) && (c == F || c == fc) && (k == F || k == fk);
  endfunction

  // command monitor and feedback responder
  always @(negedge clk) begin
    cyc++;
    if (!rst && apply_pend) begin
      if (apply_cnt == 0) begin
        fb_ok = 1'b1;
        apply_pend = 1'b0;
      end else apply_cnt--;
    end
    if (!rst && cmd_valid) begin
      logic [30:0] e;
      check(!apply_pend, "R4", "command before completion seen", 1, 0);
      if (last_slow)
        check(cyc - last_cmd_cyc >= WAITV + 2, "R6", "gap after command", cyc - last_cmd_cyc, WAITV + 2);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected command", int'(cmd_word), 0);
      end else begin
        e = exp_q.pop_front();
        check(cmd_word == e, tag_of(e), "command word (R11 format)", int'(cmd_word), int'(e));
      end
      if (cmd_word[30:28] != 3'd4) check(busy, "R2", "busy during command", int'(busy), 1);
      last_cmd_cyc = cyc;
      last_slow = (cmd_word[30:28] != 3'd5);
      case (cmd_word[30:28])
        3'd1, 3'd2: begin
          if (cmd_word[30:28] == 3'd2 && f_mode == 1) f_mode = -1;
          fb_ok = 1'b0;
          apply_cnt = APPLY_DELAY;
          apply_pend = 1'b1;
        end
        3'd3: fb_ok = !hit(cmd_word[27:24], cmd_word[23:20], cmd_word[19:16]);
        3'd4: f_disabled = 1'b1;
        default: ;
      endcase
    end
  end

  // watchdog
  always @(posedge clk) if (cyc > 150000) begin
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic exp_cycle(int ng, int ns);
    for (int s = 0; s < ns; s++) begin
      for (int w = 0; w < 4; w++) exp_q.push_back(mk(5, F, F, 4'(w), mem_word(s*4 + w)));
      for (int g = 0; g < ng; g++) exp_q.push_back(mk(1, 4'(g), F, F, 16'h0));
    end
    exp_q.push_back(mk(3, F, F, F, 16'h0));
  endtask

  task automatic exp_diag(int ng);
    if (f_mode == 2) begin
      for (int g = 0; g < ng; g++) exp_q.push_back(mk(3, 4'(g), F, F, 16'h0));
      return;
    end
    for (int g = 0; g <= int'(fg); g++) exp_q.push_back(mk(3, 4'(g), F, F, 16'h0));
    for (int c = 0; c <= int'(fc); c++) exp_q.push_back(mk(3, fg, 4'(c), F, 16'h0));
    for (int k = 0; k <= int'(fk); k++) exp_q.push_back(mk(3, fg, fc, 4'(k), 16'h0));
    exp_q.push_back(mk(2, fg, fc, fk, 16'h0));
    exp_q.push_back(mk(3, fg, fc, fk, 16'h0));
    if (f_mode == 0) exp_q.push_back(mk(4, fg, fc, fk, 16'h0));
  endtask

  task automatic run(input logic retrigger);
    int n = 0;
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    check(busy, "R2", "busy after trigger", int'(busy), 1);
    if (retrigger) begin
      repeat (12) @(negedge clk);
      trigger = 1'b1;
      @(negedge clk);
      trigger = 1'b0;
    end
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    check(!busy, "R2", "busy low after return to idle", int'(busy), 0);
    check(exp_q.size() == 0, "R8", "expected commands left over", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !cmd_valid && !fault_log_valid, "R1", "reset state",
          {29'd0, busy, cmd_valid, fault_log_valid}, 0);

    // healthy array, retrigger while busy ignored
    exp_cycle(3, 2);
    run(1'b1);

    // permanent fault at group 1 cluster 1 core 2
    f_mode = 0; fg = 4'd1; fc = 4'd1; fk = 4'd2;
    exp_cycle(3, 2);
    exp_diag(3);
    run(1'b0);
    check(fault_log_valid && fault_log == 12'h112, "R9", "fault log after disable", int'(fault_log), 12'h112);

    // transient fault at the last group, cleared by retest
    f_mode = 1; f_disabled = 1'b0; fg = 4'd2; fc = 4'd0; fk = 4'd0;
    exp_cycle(3, 2);
    exp_diag(3);
    run(1'b0);
    check(fault_log == 12'h112, "R10", "log unchanged after transient", int'(fault_log), 12'h112);

    // fault gone before the group scan
    f_mode = 2;
    exp_cycle(3, 2);
    exp_diag(3);
    run(1'b0);
    check(fault_log == 12'h112, "R8", "log unchanged after empty scan", int'(fault_log), 12'h112);

    // disabled core no longer reports; different schedule
    f_mode = 0; f_disabled = 1'b1; fg = 4'd0; fc = 4'd0; fk = 4'd0;
    cfg_groups = 4'd1; cfg_snippets = 4'd3;
    exp_cycle(1, 3);
    run(1'b0);
    check(fault_log_valid && fault_log == 12'h112, "R10", "log sticky", int'(fault_log), 12'h112);

    // new permanent fault, single core per cluster edge
    f_disabled = 1'b0; fg = 4'd0; fc = 4'd0; fk = 4'd0;
    cfg_groups = 4'd2; cfg_snippets = 4'd1; cfg_cores = 4'd1;
    exp_cycle(2, 1);
    exp_diag(2);
    run(1'b0);
    check(fault_log == 12'h000, "R10", "log holds last disabled", int'(fault_log), 12'h000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule